// File: doc/BRIEF.md
# Timing Mode Decoder with Alarm Encoder

This block turns two external control lines into one of four operating modes for a reference clock unit: free run, locked to reference one, locked to reference two, or holdover. From the accepted mode it drives the enables that steer the phase-locked loop: lock to a reference, hold the last tuning value, or run free. It also drives a reference select for the input multiplexer. A two-bit status output reports the accepted mode.

A two-bit alarm code summarises three fault inputs from the loop and its monitors (reference missing, loop out of lock, tuning near its limit) together with the operating mode. Both outputs move only on a millisecond tick, through bounded delay windows. A short disturbance on the control lines therefore never reaches the loop, and an alarm does not chatter while a reference comes and goes. With no control applied, the block sits in free run with its alarm raised.

Top module: `tmode_ctrl`

## Requirements
- R1: After reset, mode_stat is 00, alarm_code is 11, free_en is 1, and lock_en, hold_en and ref_sel are 0.
- R2: The accepted mode is taken from {ctl_b, ctl_a} and reported on mode_stat. The codes are 00 for free run (both lines low), 01 for reference one (ctl_a high only), 10 for reference two (ctl_b high only) and 11 for holdover (both high).
- R3: Exactly one of lock_en, hold_en and free_en is high at any time. lock_en is high in modes 01 and 10, hold_en in 11 and free_en in 00. ref_sel is 1 only in mode 10. These enables follow mode_stat one clock later.
- R4: After the control lines change to a new mode and stay there, mode_stat takes the new code no earlier than 2 ms and no later than 4.125 ms after the change.
- R5: A control pattern that holds for less than 2 ms before returning to the accepted mode leaves mode_stat and the enables unchanged.
- R6: alarm_code is 11 when lock_lost is set or the mode is free run or holdover. Otherwise it is 10 when ref_lost is set, 01 when tune_lim is set, and 00 when none of them is set. Loss of lock ranks highest and tune limit lowest.
- R7: When a condition with a higher alarm code appears, for example loss of reference, alarm_code takes the new code no earlier than 2 ms and no later than 6.125 ms after it appears.
- R8: When a condition clears and the code falls, for example on return of the reference, alarm_code takes the lower code within 2.125 ms.
- R9: In a locked mode with only tune_lim set, alarm_code is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| ctl_a | input | 1 | Mode control line A, asynchronous |
| ctl_b | input | 1 | Mode control line B, asynchronous |
| ref_lost | input | 1 | Selected reference missing, asynchronous |
| lock_lost | input | 1 | Loop out of lock, asynchronous |
| tune_lim | input | 1 | Tuning near its range limit, asynchronous |
| mode_stat | output | 2 | Accepted mode code |
| alarm_code | output | 2 | Encoded alarm |
| lock_en | output | 1 | Loop tracks a reference |
| ref_sel | output | 1 | Reference select, 1 for reference two |
| hold_en | output | 1 | Loop holds its last tuning value |
| free_en | output | 1 | Loop runs free |

## Verification
The assertions assume that ms_tick is a single-cycle pulse and that ticks are far apart compared with the two-stage synchronizer. The bench drives one tick every 20 cycles. They also assume that the control and fault lines change no faster than the synchronizer can follow. The bench changes every input at the falling edge and holds each level for many cycles. In the bench a millisecond is 20 clocks, so each delay window is checked in clock counts scaled from the millisecond bounds.

// File: rtl/tmode_pkg.sv
package tmode_pkg;

  typedef enum logic [1:0] {
    MD_FREE = 2'b00,
    MD_REF1 = 2'b01,
    MD_REF2 = 2'b10,
    MD_HOLD = 2'b11
  } tm_mode_e;

  localparam logic [1:0] AL_NONE = 2'b00;
  localparam logic [1:0] AL_TUNE = 2'b01;
  localparam logic [1:0] AL_REF  = 2'b10;
  localparam logic [1:0] AL_MAJ  = 2'b11;

  // Codes rank by severity: a larger code is a more serious alarm.
  function automatic logic [1:0] alarm_of(input logic [1:0] mode,
                                          input logic lost_ref,
                                          input logic lost_lock,
                                          input logic tune);
    if (lost_lock || mode == MD_FREE || mode == MD_HOLD) return AL_MAJ;
    else if (lost_ref)                                   return AL_REF;
    else if (tune)                                       return AL_TUNE;
    else                                                 return AL_NONE;
  endfunction

endpackage

// File: rtl/tmode_sync.sv
module tmode_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/tmode_debounce.sv
// Holds a value until the input has stayed at a new value for a number of
// ticks. The tick count is RISE_TICKS when the new value is numerically
// larger and FALL_TICKS when it is smaller.
module tmode_debounce #(
  parameter int             W          = 2,
  parameter int             RISE_TICKS = 3,
  parameter int             FALL_TICKS = 1,
  parameter logic [W-1:0]   INIT       = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int MAXT = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [W-1:0]  pend;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    lim = (pend > dout) ? CW'(RISE_TICKS - 1) : CW'(FALL_TICKS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= INIT;
      dout <= INIT;
      cnt  <= '0;
    end else if (din != pend) begin
      pend <= din;
      cnt  <= '0;
    end else if (pend == dout) begin
      cnt  <= '0;
    end else if (tick) begin
      if (cnt == lim) begin
        dout <= pend;
        cnt  <= '0;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end
  end

  // R4 / R7: the output only moves on the edge that sees a tick.
  p_moves_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> $past(tick));

  // R5: the output can only take a value the input was holding.
  p_takes_held_input_r5: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (dout == $past(din)));

endmodule

// File: rtl/tmode_ctrl.sv
module tmode_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int MODE_TICKS  = 3,
  parameter int ALM_ON_TICKS  = 3,
  parameter int ALM_OFF_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       ctl_a,
  input  logic       ctl_b,
  input  logic       ref_lost,
  input  logic       lock_lost,
  input  logic       tune_lim,
  output logic [1:0] mode_stat,
  output logic [1:0] alarm_code,
  output logic       lock_en,
  output logic       ref_sel,
  output logic       hold_en,
  output logic       free_en
);
  import tmode_pkg::*;

  localparam int NIN = 5;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] syn_in;
  logic [1:0]     want_mode;
  logic [1:0]     want_alarm;

  assign raw_in = {tune_lim, lock_lost, ref_lost, ctl_b, ctl_a};

  tmode_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .d_sync  (syn_in)
  );

  // Mode code is {B, A}: A alone gives reference one, B alone reference two.
  assign want_mode = {syn_in[1], syn_in[0]};

  tmode_debounce #(.W(2), .RISE_TICKS(MODE_TICKS), .FALL_TICKS(MODE_TICKS),
                   .INIT(MD_FREE)) u_mode (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .din  (want_mode),
    .dout (mode_stat)
  );

  assign want_alarm = alarm_of(mode_stat, syn_in[2], syn_in[3], syn_in[4]);

  tmode_debounce #(.W(2), .RISE_TICKS(ALM_ON_TICKS), .FALL_TICKS(ALM_OFF_TICKS),
                   .INIT(AL_MAJ)) u_alarm (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .din  (want_alarm),
    .dout (alarm_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_en <= 1'b0;
      ref_sel <= 1'b0;
      hold_en <= 1'b0;
      free_en <= 1'b1;
    end else begin
      lock_en <= (mode_stat == MD_REF1) || (mode_stat == MD_REF2);
      ref_sel <= (mode_stat == MD_REF2);
      hold_en <= (mode_stat == MD_HOLD);
      free_en <= (mode_stat == MD_FREE);
    end
  end

  // R3: the loop is driven in exactly one way.
  p_one_enable_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot({lock_en, hold_en, free_en}));

  // R3: the second reference is selected only while locking.
  p_sel_needs_lock_r3: assert property (@(posedge clk) disable iff (rst)
    ref_sel |-> lock_en);

endmodule

// File: tb/test_tmode_ctrl.sv
module test_tmode_ctrl;

  localparam int TICK_CYC = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0;
  logic       ctl_a = 1'b0, ctl_b = 1'b0;
  logic       ref_lost = 1'b0, lock_lost = 1'b0, tune_lim = 1'b0;
  logic [1:0] mode_stat, alarm_code;
  logic       lock_en, ref_sel, hold_en, free_en;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmode_ctrl i_tmode_ctrl (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .ref_lost(ref_lost), .lock_lost(lock_lost), .tune_lim(tune_lim),
    .mode_stat(mode_stat), .alarm_code(alarm_code), .lock_en(lock_en),
    .ref_sel(ref_sel), .hold_en(hold_en), .free_en(free_en)
  );

  initial begin
    forever begin
      repeat (TICK_CYC - 1) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts clocks until sig reaches want, giving up after limit.
  task automatic wait_mode(input logic [1:0] want, output int n);
    n = 0;
    while (mode_stat != want && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_alarm(input logic [1:0] want, output int n);
    n = 0;
    while (alarm_code != want && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(mode_stat == 2'b00, "R1 mode", mode_stat, 0);
    check(alarm_code == 2'b11, "R1 alarm", alarm_code, 3);
    check({lock_en, hold_en, free_en, ref_sel} == 4'b0010, "R1 enables",
          {lock_en, hold_en, free_en, ref_sel}, 2);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    check(mode_stat == 2'b00, "R2 default free run", mode_stat, 0);
  endtask

  task automatic t_mode(input logic a, input logic b, input logic [1:0] exp);
    int n;
    @(negedge clk);
    ctl_a = a;
    ctl_b = b;
    wait_mode(exp, n);
    check(mode_stat == exp, "R2 mode code", mode_stat, exp);
    check(n >= 2 * TICK_CYC && n <= (4125 * TICK_CYC) / 1000, "R4 status delay", n, 3 * TICK_CYC);
    repeat (2) @(negedge clk);
    check(lock_en == (exp == 2'b01 || exp == 2'b10), "R3 lock_en", lock_en, exp == 2'b01 || exp == 2'b10);
    check(hold_en == (exp == 2'b11), "R3 hold_en", hold_en, exp == 2'b11);
    check(free_en == (exp == 2'b00), "R3 free_en", free_en, exp == 2'b00);
    check(ref_sel == (exp == 2'b10), "R3 ref_sel", ref_sel, exp == 2'b10);
  endtask

  task automatic t_glitch(input logic a, input logic b);
    logic [1:0] keep;
    logic       ka, kb;
    keep = mode_stat;
    ka = ctl_a;
    kb = ctl_b;
    @(negedge clk);
    ctl_a = a;
    ctl_b = b;
    repeat (30) @(negedge clk);
    ctl_a = ka;
    ctl_b = kb;
    repeat (6 * TICK_CYC) @(negedge clk);
    check(mode_stat == keep, "R5 short pattern ignored", mode_stat, keep);
    check(hold_en == (keep == 2'b11) && free_en == (keep == 2'b00), "R5 enables kept",
          {hold_en, free_en}, {keep == 2'b11, keep == 2'b00});
  endtask

  // Applies fault levels and checks the alarm code and its delay window.
  task automatic t_alarm(input logic lor, input logic lol, input logic tvl,
                         input logic [1:0] exp, input int lo, input int hi,
                         input string req);
    int n;
    @(negedge clk);
    ref_lost  = lor;
    lock_lost = lol;
    tune_lim  = tvl;
    wait_alarm(exp, n);
    check(alarm_code == exp, req, alarm_code, exp);
    check(n >= lo && n <= hi, {req, " delay"}, n, hi);
    repeat (5 * TICK_CYC) @(negedge clk);
    check(alarm_code == exp, {req, " steady"}, alarm_code, exp);
  endtask

  localparam int ON_LO  = 2 * TICK_CYC;
  localparam int ON_HI  = (6125 * TICK_CYC) / 1000;
  localparam int OFF_HI = (2125 * TICK_CYC) / 1000;

  initial begin
    t_reset();
    t_mode(1'b1, 1'b0, 2'b01);
    t_alarm(0, 0, 0, 2'b00, 0, OFF_HI, "R6 locked no fault");
    t_alarm(1, 0, 0, 2'b10, ON_LO, ON_HI, "R7 loss of reference");
    t_alarm(0, 0, 0, 2'b00, 0, OFF_HI, "R8 reference returns");
    t_alarm(0, 0, 1, 2'b01, ON_LO, ON_HI, "R9 tune limit");
    t_alarm(1, 0, 1, 2'b10, ON_LO, ON_HI, "R6 reference over tune");
    t_alarm(1, 1, 1, 2'b11, ON_LO, ON_HI, "R6 lock over reference");
    t_alarm(1, 0, 1, 2'b10, 0, OFF_HI, "R8 lock regained");
    t_alarm(0, 0, 0, 2'b00, 0, OFF_HI, "R8 all cleared");
    t_mode(1'b0, 1'b1, 2'b10);
    t_glitch(1'b1, 1'b1);
    t_glitch(1'b0, 1'b0);
    t_alarm(0, 0, 0, 2'b00, 0, 0, "R6 ref two normal");
    t_mode(1'b1, 1'b1, 2'b11);
    t_alarm(0, 0, 0, 2'b11, 0, ON_HI, "R6 holdover alarm");
    t_mode(1'b0, 1'b0, 2'b00);
    t_alarm(0, 0, 0, 2'b11, 0, 0, "R6 free run alarm");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(1_500_000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule